// File: doc/BRIEF.md
# Ping-Pong IN Endpoint Buffer

This block holds outgoing packet data for a single device-to-host endpoint. A CPU writes bytes into the bank it currently owns, then hands that bank to the host side with a commit pulse. The host side answers each IN token either with the oldest committed bank (data pulse, length, and bank index, with bytes read through a random-access read port) or with NAK when no bank is committed. A host ACK returns the bank to the CPU. A host abort throws away every pending bank.

With `dual_mode` high, two banks alternate strictly (0, 1, 0, ...). The CPU can fill one bank while the other waits for the host. When a commit leaves the CPU on a bank that is already free, the transmit-ready flag rises again straight away. With `dual_mode` low, only bank 0 is used. `dual_mode` may only change while no bank is committed and both pointers sit at bank 0, for example right after an abort. The bank size is the parameter `MAX_PKT` (default 64 bytes). Each bank records the byte count it held at commit, so short packets keep their true length.

Top module: `usb_in_pingpong`

## Requirements
- R1: After reset `cpu_rdy` and `cpu_wr_allow` are 1, `bank_valid` is 0, and `host_resp_data`/`host_resp_nak` are 0.
- R2: `cpu_wr_allow` reads 0 from the cycle after the `MAX_PKT`-th byte write into the current bank. A write while it is 0 is ignored: the committed length stays `MAX_PKT` and the stored bytes are unchanged.
- R3: A commit of a free CPU bank sets that bank's bit in `bank_valid` (bit 0 for bank 0, bit 1 for bank 1) one cycle later. The bank records the number of bytes written since the bank was last emptied.
- R4: An IN request with no committed bank gives `host_resp_nak`=1 and `host_resp_data`=0 one cycle later. With a committed bank it gives `host_resp_data`=1, `host_resp_len` equal to the recorded length, and `host_resp_bank`. `host_rd_data` returns byte `host_rd_addr` of that bank.
- R5: A host ACK clears the `bank_valid` bit of the oldest committed bank one cycle later. If that bank is the CPU's current bank, `cpu_rdy` and `cpu_wr_allow` become 1 one cycle later.
- R6: In two-bank mode, a commit while the other bank is free sets `cpu_rdy` one cycle later and keeps `cpu_wr_allow` at 1.
- R7: In two-bank mode, banks are filled and sent in strict alternation, with the oldest committed bank sent first.
- R8: A `cpu_rdy_ack` pulse clears `cpu_rdy` one cycle later unless a set event occurs in the same cycle. `ep_irq` equals `cpu_rdy` AND `cpu_rdy_ie`.
- R9: A `host_abort` pulse gives `bank_valid`=0, both bank pointers at bank 0, and `cpu_rdy`=1 one cycle later.
- R10: In single-bank mode every commit and every response uses bank 0 (`host_resp_bank`=0).
- R11: When both banks are committed, `cpu_wr_allow` is 0, and further commit pulses and writes change neither bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 = two banks, 0 = bank 0 only |
| cpu_wr_en | input | 1 | Byte write strobe |
| cpu_wr_data | input | 8 | Byte to write |
| cpu_wr_allow | output | 1 | Current CPU bank accepts bytes |
| cpu_commit | input | 1 | Pulse: hand current bank to host |
| cpu_rdy | output | 1 | Transmit-ready flag |
| cpu_rdy_ack | input | 1 | Pulse: clear transmit-ready |
| cpu_rdy_ie | input | 1 | Interrupt enable for transmit-ready |
| ep_irq | output | 1 | Endpoint interrupt |
| host_in_req | input | 1 | Pulse: IN token received |
| host_ack | input | 1 | Pulse: host acknowledged the sent bank |
| host_abort | input | 1 | Pulse: discard all pending banks |
| host_resp_data | output | 1 | Response: data packet follows |
| host_resp_nak | output | 1 | Response: NAK |
| host_resp_len | output | $clog2(MAX_PKT+1) | Byte count of the answered bank |
| host_resp_bank | output | 1 | Index of the answered bank |
| host_rd_addr | input | $clog2(MAX_PKT) | Byte index into the oldest committed bank |
| host_rd_data | output | 8 | Byte at `host_rd_addr` |
| bank_valid | output | 2 | Committed flag per bank |

## Verification
The hardest state to reach is the one where both banks are committed. It needs two commits with no ACK between them. Only from that state can the bench show that the wait-for-free path re-arms `cpu_rdy`, as opposed to the immediate re-arm that follows a dual-mode commit. The bench builds this state in a directed test. It fires extra commits and writes that must be ignored, then drains the banks one at a time and checks the order, the lengths and the flag edges. The 64-byte fill with one extra write covers the full-bank boundary.

// File: rtl/usb_inbuf_pkg.sv
package usb_inbuf_pkg;
  localparam int NUM_BANKS = 2;

  // Bank that follows `cur`; single-bank mode always stays on bank 0.
  function automatic logic step_bank(input logic cur, input logic dual);
    return dual ? ~cur : 1'b0;
  endfunction

  // True while a bank holding `cnt` bytes can take one more.
  function automatic logic room_left(input int cnt, input int lim);
    return cnt < lim;
  endfunction
endpackage

// File: rtl/usb_inbuf_store.sv
module usb_inbuf_store #(
  parameter int MAX_PKT = 64,
  parameter int AW = $clog2(MAX_PKT),
  parameter int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          wr_fire,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit_fire,
  input  logic          commit_bank,
  input  logic [CW-1:0] commit_len,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] rd_len
);
  import usb_inbuf_pkg::*;

  logic [7:0]    byte_q [NUM_BANKS];
  logic [CW-1:0] len_q  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [7:0]    mem [MAX_PKT];
    logic [CW-1:0] len;
    always_ff @(posedge clk) begin
      if (wr_fire && wr_bank == 1'(b)) mem[wr_addr] <= wr_data;
      if (commit_fire && commit_bank == 1'(b)) len <= commit_len;
    end
    assign byte_q[b] = mem[rd_addr];
    assign len_q[b]  = len;
  end

  assign rd_data = byte_q[rd_bank];
  assign rd_len  = len_q[rd_bank];
endmodule

// File: rtl/usb_inbuf_ctrl.sv
module usb_inbuf_ctrl #(
  parameter int MAX_PKT = 64,
  parameter int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic          wr_en,
  input  logic          commit,
  input  logic          rdy_ack,
  input  logic          in_req,
  input  logic          host_ack,
  input  logic          abort,
  input  logic [CW-1:0] bank_len,
  output logic          wr_fire,
  output logic          commit_fire,
  output logic [CW-1:0] wr_cnt,
  output logic          cpu_bank,
  output logic          host_bank,
  output logic [1:0]    bank_full,
  output logic          wr_allow,
  output logic          rdy,
  output logic          resp_data,
  output logic          resp_nak,
  output logic [CW-1:0] resp_len,
  output logic          resp_bank
);
  import usb_inbuf_pkg::*;

  logic          cpu_q, host_q, cpu_n, host_n;
  logic [1:0]    full_q, full_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          allow_q, allow_n, rdy_q, rdy_n, free_q, free_n;
  logic          ack_fire, rdy_set;

  always_comb begin
    commit_fire = commit & ~full_q[cpu_q] & ~abort;
    wr_fire     = wr_en & allow_q & ~commit_fire & ~abort;
    ack_fire    = host_ack & full_q[host_q] & ~abort;

    full_n = full_q;
    if (ack_fire)    full_n[host_q] = 1'b0;
    if (commit_fire) full_n[cpu_q]  = 1'b1;
    if (abort)       full_n = '0;

    cpu_n  = abort ? 1'b0 : (commit_fire ? step_bank(cpu_q, dual) : cpu_q);
    host_n = abort ? 1'b0 : (ack_fire ? step_bank(host_q, dual) : host_q);
    cnt_n  = (abort | commit_fire) ? '0 : (wr_fire ? cnt_q + 1'b1 : cnt_q);

    free_n  = ~full_n[cpu_n];
    allow_n = free_n & room_left(int'(cnt_n), MAX_PKT);
    rdy_set = abort | (commit_fire & free_n) | (free_n & ~free_q);
    rdy_n   = rdy_set ? 1'b1 : (rdy_ack ? 1'b0 : rdy_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q    <= '0;
      cpu_q     <= 1'b0;
      host_q    <= 1'b0;
      cnt_q     <= '0;
      allow_q   <= 1'b1;
      rdy_q     <= 1'b1;
      free_q    <= 1'b1;
      resp_data <= 1'b0;
      resp_nak  <= 1'b0;
      resp_len  <= '0;
      resp_bank <= 1'b0;
    end else begin
      full_q    <= full_n;
      cpu_q     <= cpu_n;
      host_q    <= host_n;
      cnt_q     <= cnt_n;
      allow_q   <= allow_n;
      rdy_q     <= rdy_n;
      free_q    <= free_n;
      resp_data <= in_req & ~abort & full_q[host_q];
      resp_nak  <= in_req & ~abort & ~full_q[host_q];
      if (in_req) begin
        resp_len  <= bank_len;
        resp_bank <= host_q;
      end
    end
  end

  assign wr_cnt    = cnt_q;
  assign cpu_bank  = cpu_q;
  assign host_bank = host_q;
  assign bank_full = full_q;
  assign wr_allow  = allow_q;
  assign rdy       = rdy_q;

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && cnt_q == CW'(MAX_PKT - 1) |=> !allow_q); // R2
  AST_COMMIT_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire && !host_ack |=> full_q[$past(cpu_q)]); // R3
  AST_NAK_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    in_req && !abort && full_q == 2'b00 |=> resp_nak && !resp_data); // R4
  AST_DUAL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    dual && commit_fire && !full_q[!cpu_q] |=> rdy_q && allow_q); // R6
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> rdy_q && full_q == 2'b00 && !cpu_q && !host_q); // R9
  AST_SINGLE_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !dual && commit_fire |=> !cpu_q); // R10
  AST_BOTH_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == 2'b11 |-> !commit_fire && !wr_fire); // R11
endmodule

// File: rtl/usb_in_pingpong.sv
module usb_in_pingpong #(
  parameter int MAX_PKT = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual_mode,
  input  logic          cpu_wr_en,
  input  logic [7:0]    cpu_wr_data,
  output logic          cpu_wr_allow,
  input  logic          cpu_commit,
  output logic          cpu_rdy,
  input  logic          cpu_rdy_ack,
  input  logic          cpu_rdy_ie,
  output logic          ep_irq,
  input  logic          host_in_req,
  input  logic          host_ack,
  input  logic          host_abort,
  output logic          host_resp_data,
  output logic          host_resp_nak,
  output logic [CW-1:0] host_resp_len,
  output logic          host_resp_bank,
  input  logic [AW-1:0] host_rd_addr,
  output logic [7:0]    host_rd_data,
  output logic [1:0]    bank_valid
);
  logic          wr_fire, commit_fire, cpu_bank, host_bank;
  logic [CW-1:0] wr_cnt, bank_len;

  usb_inbuf_ctrl #(.MAX_PKT(MAX_PKT), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dual(dual_mode),
    .wr_en(cpu_wr_en), .commit(cpu_commit), .rdy_ack(cpu_rdy_ack),
    .in_req(host_in_req), .host_ack(host_ack), .abort(host_abort),
    .bank_len(bank_len), .wr_fire(wr_fire), .commit_fire(commit_fire),
    .wr_cnt(wr_cnt), .cpu_bank(cpu_bank), .host_bank(host_bank),
    .bank_full(bank_valid), .wr_allow(cpu_wr_allow), .rdy(cpu_rdy),
    .resp_data(host_resp_data), .resp_nak(host_resp_nak),
    .resp_len(host_resp_len), .resp_bank(host_resp_bank)
  );

  usb_inbuf_store #(.MAX_PKT(MAX_PKT), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .wr_fire(wr_fire), .wr_bank(cpu_bank),
    .wr_addr(wr_cnt[AW-1:0]), .wr_data(cpu_wr_data),
    .commit_fire(commit_fire), .commit_bank(cpu_bank), .commit_len(wr_cnt),
    .rd_bank(host_bank), .rd_addr(host_rd_addr),
    .rd_data(host_rd_data), .rd_len(bank_len)
  );

  assign ep_irq = cpu_rdy & cpu_rdy_ie;
endmodule

// File: tb/usb_in_pingpong_tb.sv
module usb_in_pingpong_tb;
  localparam int MAX = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dual_mode = 1'b0, cpu_wr_en = 1'b0, cpu_commit = 1'b0;
  logic cpu_rdy_ack = 1'b0, cpu_rdy_ie = 1'b0;
  logic host_in_req = 1'b0, host_ack = 1'b0, host_abort = 1'b0;
  logic [7:0] cpu_wr_data = '0;
  logic [5:0] host_rd_addr = '0;
  logic cpu_wr_allow, cpu_rdy, ep_irq, host_resp_data, host_resp_nak, host_resp_bank;
  logic [6:0] host_resp_len;
  logic [7:0] host_rd_data;
  logic [1:0] bank_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {dual, length, first byte}
  localparam logic [16:0] VECS [6] = '{
    {1'b0, 8'd1,  8'h10}, {1'b0, 8'd5,  8'h20}, {1'b0, 8'd17, 8'h40},
    {1'b1, 8'd3,  8'h60}, {1'b1, 8'd9,  8'h80}, {1'b1, 8'd2,  8'hA0}};

  always #5 clk = ~clk;

  usb_in_pingpong #(.MAX_PKT(MAX)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic wr(input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_wr_data = d; tick; cpu_wr_en = 1'b0;
  endtask
  task automatic commit_p; cpu_commit = 1'b1; tick; cpu_commit = 1'b0; endtask
  task automatic rack_p; cpu_rdy_ack = 1'b1; tick; cpu_rdy_ack = 1'b0; endtask
  task automatic req_p; host_in_req = 1'b1; tick; host_in_req = 1'b0; endtask
  task automatic ack_p; host_ack = 1'b1; tick; host_ack = 1'b0; endtask
  task automatic abort_p; host_abort = 1'b1; tick; host_abort = 1'b0; endtask
  task automatic rd_chk(input int a, input int exp, input string req);
    host_rd_addr = 6'(a); #1;
    chk(host_rd_data == 8'(exp), req, host_rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bank_exp;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R1 reset state
    chk(cpu_rdy == 1'b1, "R1 rdy", cpu_rdy, 1);
    chk(cpu_wr_allow == 1'b1, "R1 allow", cpu_wr_allow, 1);
    chk(bank_valid == 2'b00, "R1 valid", bank_valid, 0);
    chk(!host_resp_data && !host_resp_nak, "R1 resp", host_resp_data, 0);
    // R8 interrupt and acknowledge
    cpu_rdy_ie = 1'b1; #1;
    chk(ep_irq == 1'b1, "R8 irq", ep_irq, 1);
    rack_p;
    chk(cpu_rdy == 1'b0 && ep_irq == 1'b0, "R8 ack", cpu_rdy, 0);
    // R4 NAK on empty
    req_p;
    chk(host_resp_nak && !host_resp_data, "R4 nak", host_resp_nak, 1);

    // Table walk
    bank_exp = 0;
    for (int v = 0; v < 6; v++) begin
      logic dm;
      int len, base;
      dm = VECS[v][16]; len = int'(VECS[v][15:8]); base = int'(VECS[v][7:0]);
      if (dm != dual_mode) begin
        abort_p; dual_mode = dm; bank_exp = 0;
      end
      for (int i = 0; i < len; i++) wr(8'(base + i));
      commit_p;
      chk(bank_valid[bank_exp] == 1'b1, "R3 valid", bank_valid, 1 << bank_exp);
      if (dm) chk(cpu_rdy && cpu_wr_allow, "R6 rearm", cpu_rdy, 1);
      rack_p;
      req_p;
      chk(host_resp_data && !host_resp_nak, "R4 data", host_resp_data, 1);
      chk(int'(host_resp_len) == len, "R3 len", host_resp_len, len);
      chk(int'(host_resp_bank) == bank_exp, dm ? "R7 bank" : "R10 bank", host_resp_bank, bank_exp);
      rd_chk(0, base, "R4 first");
      rd_chk(len - 1, base + len - 1, "R4 last");
      ack_p;
      chk(bank_valid == 2'b00, "R5 free", bank_valid, 0);
      chk(cpu_rdy == !dm, "R5 rdy", cpu_rdy, int'(!dm));
      if (dm) bank_exp = 1 - bank_exp;
    end

    // R2 full bank, extra write ignored
    abort_p; dual_mode = 1'b0;
    for (int i = 0; i < MAX; i++) begin
      chk(cpu_wr_allow == 1'b1, "R2 open", cpu_wr_allow, 1);
      wr(8'(i));
    end
    chk(cpu_wr_allow == 1'b0, "R2 closed", cpu_wr_allow, 0);
    wr(8'hEE);
    commit_p;
    req_p;
    chk(int'(host_resp_len) == MAX, "R2 len", host_resp_len, MAX);
    rd_chk(MAX - 1, MAX - 1, "R2 byte");
    rd_chk(0, 0, "R2 byte0");
    ack_p;

    // R11 both banks committed, then ordered drain
    abort_p; dual_mode = 1'b1;
    wr(8'h11); wr(8'h12); commit_p;
    wr(8'h21); commit_p;
    chk(bank_valid == 2'b11, "R11 both", bank_valid, 3);
    chk(cpu_wr_allow == 1'b0, "R11 allow", cpu_wr_allow, 0);
    rack_p;
    wr(8'hFF); commit_p;
    chk(bank_valid == 2'b11 && cpu_rdy == 1'b0, "R11 hold", cpu_rdy, 0);
    req_p;
    chk(host_resp_bank == 1'b0 && host_resp_len == 7'd2, "R7 first", host_resp_len, 2);
    rd_chk(1, 8'h12, "R11 byte");
    ack_p;
    chk(cpu_rdy && cpu_wr_allow, "R5 dual free", cpu_rdy, 1);
    req_p;
    chk(host_resp_bank == 1'b1 && host_resp_len == 7'd1, "R7 second", host_resp_len, 1);
    rd_chk(0, 8'h21, "R7 byte");
    ack_p;

    // R9 abort
    wr(8'h55); commit_p; rack_p;
    chk(bank_valid != 2'b00, "R9 pre", bank_valid, 1);
    abort_p;
    chk(bank_valid == 2'b00 && cpu_rdy == 1'b1, "R9 clean", bank_valid, 0);
    req_p;
    chk(host_resp_nak == 1'b1, "R9 nak", host_resp_nak, 1);
    wr(8'h77); commit_p; req_p;
    chk(host_resp_bank == 1'b0 && host_resp_data, "R9 bank0", host_resp_bank, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule